// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block turns several reset causes into one stretched system reset and drives it out as a complementary pair: an active-low output and an active-high output. The causes are a digitised supply-good comparator, a watchdog expiry request from elsewhere on the chip, and the two reset pins themselves. The pins are bidirectional. The block drives each pin through an output-enable and reads back the pin's external level, so another device can pull a pin to start a reset.

Every cause is stretched to the same fixed timeout, counted in cycles of the free-running system clock. A short dip on the supply-good input is filtered out. An independent auxiliary under-voltage comparator is passed straight through to its own flag output, with no timing at all.

Top module: `rsc_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, the reset is asserted: `rst_o`=1, `rstn_o`=0 and both drive enables are 1. After `rst_n` rises with the supply good, the reset releases by itself.
- R2: If `supply_ok_i` is low for at least `GLITCH_CYCLES` consecutive clock cycles, the reset asserts and stays asserted for as long as the input stays low.
- R3: If `supply_ok_i` is low for fewer than `GLITCH_CYCLES` consecutive cycles, no reset occurs.
- R4: After a qualifying supply dip ends, the reset holds for `TIMEOUT_CYCLES` more cycles. For a dip lasting L ≥ `GLITCH_CYCLES` input cycles, the reset is asserted for L + `TIMEOUT_CYCLES` − `GLITCH_CYCLES` cycles in total.
- R5: `rstn_o` is always the inverse of `rst_o`. `rstn_oe_o` (drive the active-low pin to 0) and `rst_oe_o` (drive the active-high pin to 1) are both 1 exactly while `rst_o` is 1.
- R6: A high-to-low transition on the external level of the active-low pin (`rstn_pad_i`) produces a reset of exactly `TIMEOUT_CYCLES` cycles.
- R7: A low-to-high transition on the external level of the active-high pin (`rst_pad_i`) produces a reset of exactly `TIMEOUT_CYCLES` cycles.
- R8: Pin transitions that occur while the block is driving its reset are ignored. In particular, the block's own drive looped back through the pins does not lengthen or repeat the pulse.
- R9: A one-cycle pulse on `wdog_expire_i` produces a reset of exactly `TIMEOUT_CYCLES` cycles.
- R10: A watchdog pulse arriving D cycles after an earlier one, while the reset is still running, restarts the count. The reset then lasts `TIMEOUT_CYCLES` + D cycles in total.
- R11: `aux_low_n_o` equals `aux_ok_i` in the same cycle, whatever the reset state.
- R12: A reset pin held steadily at its asserted level causes only the one edge-started pulse, not a continuous or repeated reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Digitised supply comparator, 1 = above trip level (asynchronous) |
| wdog_expire_i | input | 1 | Watchdog expiry request, one-cycle pulse, same clock domain |
| aux_ok_i | input | 1 | Auxiliary comparator, 1 = above its threshold |
| rstn_pad_i | input | 1 | External level of the active-low reset pin (asynchronous) |
| rst_pad_i | input | 1 | External level of the active-high reset pin (asynchronous) |
| rstn_o | output | 1 | Active-low reset level |
| rst_o | output | 1 | Active-high reset level |
| rstn_oe_o | output | 1 | Enable to pull the active-low pin to 0 |
| rst_oe_o | output | 1 | Enable to pull the active-high pin to 1 |
| aux_low_n_o | output | 1 | Untimed auxiliary under-voltage flag, 0 = low |

## Verification
The bench wires the drive enables back onto the pin inputs the way open-drain pads would, and measures every reset as a count of asserted cycles.

- **Self-retrigger.** A design that re-armed on its own looped-back drive would show pulses longer than the timeout.
- **Supply dips at the filter boundary.** Dips of exactly `GLITCH_CYCLES` − 1 and `GLITCH_CYCLES` cycles are applied, which exposes an off-by-one in the glitch counter as a missing or spurious reset.
- **Overlapping watchdog pulses.** A counter that ignored a new cause would give `TIMEOUT_CYCLES` instead of `TIMEOUT_CYCLES` + D.
- **Pin held asserted.** A level-sensitive pin decoder would keep the reset asserted indefinitely.

// File: rtl/rsc_pkg.sv
// Shared definitions for the supervisory reset controller.
// Assumes nothing beyond a single clock domain for the internal logic.
package rsc_pkg;

    // One flag per source that can start or hold a reset.
    typedef struct packed {
        logic supply_low;   // filtered supply dip, a level that holds the reset
        logic wdog;         // watchdog expiry pulse
        logic pin_lo_edge;  // falling edge seen on the active-low pin
        logic pin_hi_edge;  // rising edge seen on the active-high pin
    } rsc_cause_t;

    // Counter width for a terminal count, never below one bit.
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
// Multi-flop synchroniser for one asynchronous input.
// Assumes STAGES >= 2. The output takes RST_VAL while rst_n is low.
module rsc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Move the sample one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_glitch.sv
// Supply glitch filter. low_o goes high only after GLITCH_CYCLES consecutive
// low samples of ok_i, and clears on the first high sample.
// Assumes ok_i is already synchronised. The reset state reports "low" so
// that power-on behaves like a supply below its trip level.
module rsc_glitch #(
    parameter int GLITCH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    output logic low_o
);
    localparam int CW = rsc_pkg::cnt_width(GLITCH_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          low_q;

    // Count consecutive low samples and declare a dip at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            low_q <= 1'b1;
        end else if (ok_i) begin
            run_q <= '0;
            low_q <= 1'b0;
        end else if (run_q == LAST) begin
            low_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_o = low_q;

    // R2
    dip_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> ($past(run_q) == LAST) && !$past(ok_i));
    // R4
    dip_clears_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_i |=> !low_q);
endmodule

// File: rtl/rsc_edge.sv
// Edge detector for one synchronised reset pin.
// Emits a one-cycle trigger when the pin moves from idle to its asserted
// level. Set ACTIVE_HIGH = 0 for a pin asserted low. mask_i suppresses
// detection while the controller itself is driving the pin.
module rsc_edge #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic mask_i,
    output logic trig_o
);
    logic asserted;
    logic prev_q;

    generate
        if (ACTIVE_HIGH) begin : g_hi
            assign asserted = lvl_i;
        end else begin : g_lo
            assign asserted = ~lvl_i;
        end
    endgenerate

    // Remember last cycle's asserted state. The pin reads as idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= asserted;
    end

    assign trig_o = asserted & ~prev_q & ~mask_i;

    // R6
    trig_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
endmodule

// File: rtl/rsc_stretch.sv
// Reset pulse stretcher. While hold_i is high, or on any kick_i, the reset
// is (re)armed with its count at zero. Once hold_i is low, the reset stays
// active for TIMEOUT_CYCLES more cycles. A new kick restarts the count.
// Assumes TIMEOUT_CYCLES >= 4, so that the synchroniser latency on
// looped-back pins stays inside the pulse.
module rsc_stretch #(
    parameter int TIMEOUT_CYCLES = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic kick_i,
    output logic active_o
);
    localparam int CW = rsc_pkg::cnt_width(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    // Arm on a cause, then count to the limit and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (hold_i || kick_i) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == LAST) active_q <= 1'b0;
            else               cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign active_o = active_q;

    // R9
    cause_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || kick_i) |=> active_q);
    // R10
    release_after_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> ($past(cnt_q) == LAST) && !$past(hold_i) && !$past(kick_i));
endmodule

// File: rtl/rsc_reset_ctrl.sv
// Supervisory reset pulse controller, top level.
// Merges a filtered supply dip, a watchdog expiry and edges on two
// bidirectional reset pins into one stretched reset. The reset leaves as a
// complementary pair of levels plus output enables for open-drain pads.
// The auxiliary comparator bypasses all timing.
// Assumes the pad inputs carry the wired pin level, including this block's
// own drive.
module rsc_reset_ctrl #(
    parameter int TIMEOUT_CYCLES = 40_000_000,
    parameter int GLITCH_CYCLES  = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic wdog_expire_i,
    input  logic aux_ok_i,
    input  logic rstn_pad_i,
    input  logic rst_pad_i,
    output logic rstn_o,
    output logic rst_o,
    output logic rstn_oe_o,
    output logic rst_oe_o,
    output logic aux_low_n_o
);
    import rsc_pkg::*;

    logic       supply_s;
    logic       pin_lo_s;
    logic       pin_hi_s;
    logic       active;
    rsc_cause_t cause;

    // Bring the three asynchronous inputs into the clock domain.
    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
        .clk(clk), .rst_n(rst_n), .d_i(supply_ok_i), .q_o(supply_s));
    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin_lo (
        .clk(clk), .rst_n(rst_n), .d_i(rstn_pad_i), .q_o(pin_lo_s));
    rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin_hi (
        .clk(clk), .rst_n(rst_n), .d_i(rst_pad_i), .q_o(pin_hi_s));

    rsc_glitch #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_glitch (
        .clk(clk), .rst_n(rst_n), .ok_i(supply_s), .low_o(cause.supply_low));

    // Pin edges are masked while the reset is driven, so the looped-back
    // drive cannot re-arm the stretcher.
    rsc_edge #(.ACTIVE_HIGH(1'b0)) u_edge_lo (
        .clk(clk), .rst_n(rst_n), .lvl_i(pin_lo_s), .mask_i(active),
        .trig_o(cause.pin_lo_edge));
    rsc_edge #(.ACTIVE_HIGH(1'b1)) u_edge_hi (
        .clk(clk), .rst_n(rst_n), .lvl_i(pin_hi_s), .mask_i(active),
        .trig_o(cause.pin_hi_edge));

    assign cause.wdog = wdog_expire_i;

    rsc_stretch #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_stretch (
        .clk(clk), .rst_n(rst_n),
        .hold_i(cause.supply_low),
        .kick_i(cause.wdog | cause.pin_lo_edge | cause.pin_hi_edge),
        .active_o(active));

    assign rst_o       = active;
    assign rstn_o      = ~active;
    assign rst_oe_o    = active;
    assign rstn_oe_o   = active;
    assign aux_low_n_o = aux_ok_i;

    // R8
    pin_edge_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause.pin_lo_edge || cause.pin_hi_edge) |-> !rst_o);
    // R2
    dip_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause.supply_low |=> rst_o && !rstn_o);
endmodule

// File: tb/sim_rsc_reset_ctrl.sv
`timescale 1ns/1ps
module sim_rsc_reset_ctrl;
    localparam int T = 40;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n, supply_ok, wdog, aux_ok;
    logic ext_lo_n, ext_hi;
    logic rstn_pad, rst_pad;
    logic rstn_o, rst_o, rstn_oe, rst_oe, aux_low_n;

    int checks = 0;
    int fails  = 0;
    int hi_cnt = 0;
    int pair_err = 0;

    always #2.5 clk = ~clk;

    // Open-drain pad model: the pin is the wired combination of the
    // external driver and this block's drive.
    assign rstn_pad = ext_lo_n & ~rstn_oe;
    assign rst_pad  = ext_hi | rst_oe;

    rsc_reset_ctrl #(.TIMEOUT_CYCLES(T), .GLITCH_CYCLES(G), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .wdog_expire_i(wdog),
        .aux_ok_i(aux_ok), .rstn_pad_i(rstn_pad), .rst_pad_i(rst_pad),
        .rstn_o(rstn_o), .rst_o(rst_o), .rstn_oe_o(rstn_oe), .rst_oe_o(rst_oe),
        .aux_low_n_o(aux_low_n));

    // Count asserted cycles and watch the output pair (R5).
    always @(negedge clk) begin
        hi_cnt = hi_cnt + (rst_o ? 1 : 0);
        if ((rstn_o !== ~rst_o) || (rstn_oe !== rst_o) || (rst_oe !== rst_o))
            pair_err = pair_err + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected reset lengths, worked out from the requirements.
    function automatic int exp_dip(input int len);
        return (len < G) ? 0 : len + T - G;
    endfunction
    function automatic int exp_restart(input int gap);
        return T + gap + 1;
    endfunction

    task automatic settle();
        repeat (T + 40) @(negedge clk);
    endtask

    task automatic wd_pulse();
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
    endtask

    task automatic dip(input int len);
        @(negedge clk); hi_cnt = 0;
        supply_ok = 1'b0;
        repeat (len) @(negedge clk);
        supply_ok = 1'b1;
        settle();
        check(hi_cnt == exp_dip(len), (len < G) ? "R3" : "R4", hi_cnt, exp_dip(len));
    endtask

    task automatic restart(input int gap);
        @(negedge clk); hi_cnt = 0;
        wd_pulse();
        repeat (gap) @(negedge clk);
        wd_pulse();
        settle();
        check(hi_cnt == exp_restart(gap), "R10", hi_cnt, exp_restart(gap));
    endtask

    // Watchdog for the bench itself.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r;
        int seed;
        bit ok;
        seed = 7;
        r = $urandom(seed);
        rst_n = 1'b0; supply_ok = 1'b1; wdog = 1'b0; aux_ok = 1'b1;
        ext_lo_n = 1'b1; ext_hi = 1'b0;
        repeat (5) @(negedge clk);
        check(rst_o == 1'b1 && rstn_o == 1'b0 && rstn_oe && rst_oe, "R1", rst_o, 1);
        aux_ok = 1'b0; #1;
        check(aux_low_n == 1'b0, "R11", aux_low_n, 0);
        aux_ok = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        settle();
        check(rst_o == 1'b0 && rstn_o == 1'b1, "R1", rst_o, 0);

        // R9: single watchdog pulse
        @(negedge clk); hi_cnt = 0;
        wd_pulse(); settle();
        check(hi_cnt == T, "R9", hi_cnt, T);

        // R2: held supply dip keeps the reset on
        @(negedge clk); supply_ok = 1'b0;
        repeat (T + 20) @(negedge clk);
        check(rst_o == 1'b1, "R2", rst_o, 1);
        supply_ok = 1'b1; settle();

        // R3 / R4: dips at the filter boundary
        dip(G - 1);
        dip(1);
        dip(G);
        dip(G + 5);

        // R6: falling edge on the active-low pin; the loopback must not retrigger (R8)
        @(negedge clk); hi_cnt = 0;
        ext_lo_n = 1'b0; repeat (3) @(negedge clk); ext_lo_n = 1'b1;
        settle();
        check(hi_cnt == T, "R6", hi_cnt, T);

        // R7: rising edge on the active-high pin
        @(negedge clk); hi_cnt = 0;
        ext_hi = 1'b1; repeat (3) @(negedge clk); ext_hi = 1'b0;
        settle();
        check(hi_cnt == T, "R7", hi_cnt, T);

        // R8: pin activity during a running reset is ignored
        @(negedge clk); hi_cnt = 0;
        wd_pulse();
        repeat (5) @(negedge clk);
        ext_lo_n = 1'b0; ext_hi = 1'b1;
        repeat (4) @(negedge clk);
        ext_lo_n = 1'b1; ext_hi = 1'b0;
        settle();
        check(hi_cnt == T, "R8", hi_cnt, T);

        // R12: active-low pin held low for a long time
        @(negedge clk); hi_cnt = 0;
        ext_lo_n = 1'b0;
        repeat (3 * T) @(negedge clk);
        check(hi_cnt == T && rst_o == 1'b0, "R12", hi_cnt, T);
        ext_lo_n = 1'b1; settle();
        check(hi_cnt == T, "R12", hi_cnt, T);

        // R10: directed and random restart gaps
        restart(1);
        restart(T - 2);
        for (int i = 0; i < 6; i++) restart(1 + ($urandom % 30));

        // Random supply dips, short and long
        for (int i = 0; i < 6; i++) dip(1 + ($urandom % 12));

        // R11: aux follows its input under random values, also during a reset
        ok = 1'b1;
        wd_pulse();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            aux_ok = 1'($urandom % 2); #1;
            if (aux_low_n !== aux_ok) ok = 1'b0;
        end
        check(ok, "R11", aux_low_n, aux_ok);
        settle();

        check(pair_err == 0, "R5", pair_err, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule